// File: doc/BRIEF.md
# Predicated Execute and Branch Redirect Unit

This unit sits between decode and execute in a three-stage pipelined 32-bit core. It keeps the decode slot and the execute slot. Each 32-bit word presented at the fetch port moves into decode on the next edge and into execute on the edge after that. While fetch, decode and execute overlap, the unit tests the 4-bit predicate in the top nibble of the executing word against the live status flags. A word whose predicate fails is dropped on the spot. The words behind it keep moving, so no cycle is lost.

When the executing word is a branch and its predicate holds, the unit works out the redirect address and asserts flush for one cycle. The flush invalidates the word in decode and the word being fetched. A branch with its link bit set also asks the register file to write the return address into register 14. The flags come from the ALU, and the unit does not change them. The register write port only carries the enable and the index; the result data comes from outside this block, except for the link value.

Top module: `cond_branch_unit`

## Requirements
- R1: The predicate is word bits [31:28]. It is tested against flags_nzcv, where bit 3 is N, bit 2 is Z, bit 1 is C and bit 0 is V. The codes are: 0 Z; 1 !Z; 2 C; 3 !C; 4 N; 5 !N; 6 V; 7 !V; 8 C&!Z; 9 !C|Z; 10 N==V; 11 N!=V; 12 !Z&(N==V); 13 Z|(N!=V).
- R2: A valid non-branch word in execute whose predicate holds raises rf_we, with rf_idx equal to word bits [15:12]. If its predicate fails, rf_we stays low.
- R3: Code 14 always executes and code 15 never executes, whatever the flags.
- R4: A word with bits [27:25] = 3'b101 is a branch. When its predicate holds, br_taken is high and br_target = its address + 8 + (sign-extended bits [23:0] × 4), taken modulo 2^32. The extreme offsets and address wrap-around are included.
- R5: When a taken branch has bit 24 set, rf_we is high, rf_idx is 14 and link_val is its address + 4. When bit 24 is clear, rf_we stays low.
- R6: A branch whose predicate fails raises neither br_taken, flush nor rf_we.
- R7: flush is high exactly when br_taken is high, and it lasts one cycle. The two words younger than the branch never raise rf_we or br_taken.
- R8: A word presented with fetch_valid in cycle k is judged in cycle k+2, using the flags of cycle k+2. A failed word does not delay the words behind it. A cycle with fetch_valid low produces nothing two cycles later.
- R9: While rst_n is low, and for the cycles before the first word reaches execute, rf_we, br_taken and flush are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_valid | input | 1 | Fetch port holds a real word |
| fetch_word | input | 32 | Word being fetched |
| fetch_pc | input | 32 | Byte address of that word |
| flags_nzcv | input | 4 | Live status flags {N,Z,C,V} |
| rf_we | output | 1 | Register write allowed for the word in execute |
| rf_idx | output | 4 | Destination register of that write |
| link_val | output | 32 | Return address for a linked branch |
| br_taken | output | 1 | A branch in execute is taken |
| br_target | output | 32 | Redirect address |
| flush | output | 1 | Invalidate the fetch and decode slots |

## Verification
Every result of a word appears combinationally in the cycle two edges after the word was offered: rf_we, rf_idx, br_taken, br_target, link_val and flush. The flush caused by that word hides the two following words in the next two cycles. The bench drives inputs on the falling edge and lets the combinational outputs settle for 1 ns. It then compares all outputs against a behavioural two-entry queue model, which it advances by one entry per cycle, so each expectation is sampled in exactly the cycle the requirement names. Sweeps cover all 16 predicates under all 16 flag patterns, branches with and without link, failed branches, both offset extremes with address wrap, and a random mix.

// File: rtl/cbu_pkg.sv
package cbu_pkg;

  localparam int unsigned XLEN     = 32;
  localparam int unsigned PRED_W   = 4;
  localparam int unsigned REGIDX_W = 4;

  typedef enum logic [PRED_W-1:0] {
    PR_EQ = 4'h0, PR_NE = 4'h1, PR_CS = 4'h2, PR_CC = 4'h3,
    PR_MI = 4'h4, PR_PL = 4'h5, PR_VS = 4'h6, PR_VC = 4'h7,
    PR_HI = 4'h8, PR_LS = 4'h9, PR_GE = 4'hA, PR_LT = 4'hB,
    PR_GT = 4'hC, PR_LE = 4'hD, PR_AL = 4'hE, PR_NV = 4'hF
  } pred_e;

  typedef struct packed {
    logic            vld;
    logic [XLEN-1:0] word;
    logic [XLEN-1:0] addr;
  } slot_t;

endpackage

// File: rtl/cbu_pred_eval.sv
module cbu_pred_eval
  import cbu_pkg::*;
(
  input  logic [PRED_W-1:0] pred,
  input  logic [3:0]        nzcv,
  output logic              pass
);

  pred_e code;
  logic  n_f, z_f, c_f, v_f;

  assign code = pred_e'(pred);
  assign n_f  = nzcv[3];
  assign z_f  = nzcv[2];
  assign c_f  = nzcv[1];
  assign v_f  = nzcv[0];

  always_comb begin
    pass = 1'b0;
    case (code)
      PR_EQ: pass = z_f;
      PR_NE: pass = !z_f;
      PR_CS: pass = c_f;
      PR_CC: pass = !c_f;
      PR_MI: pass = n_f;
      PR_PL: pass = !n_f;
      PR_VS: pass = v_f;
      PR_VC: pass = !v_f;
      PR_HI: pass = c_f && !z_f;
      PR_LS: pass = !c_f || z_f;
      PR_GE: pass = (n_f == v_f);
      PR_LT: pass = (n_f != v_f);
      PR_GT: pass = !z_f && (n_f == v_f);
      PR_LE: pass = z_f || (n_f != v_f);
      PR_AL: pass = 1'b1;
      PR_NV: pass = 1'b0;
    endcase
  end

endmodule

// File: rtl/cbu_slot_chain.sv
module cbu_slot_chain
  import cbu_pkg::*;
#(
  parameter int unsigned DEPTH = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  kill,
  input  slot_t slot_in,
  output slot_t slot_out
);

  slot_t stg_q [DEPTH];
  slot_t stg_d [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_comb begin
        stg_d[g] = slot_in;
        if (kill) stg_d[g].vld = 1'b0;
      end
    end else begin : g_body
      always_comb begin
        stg_d[g] = stg_q[g-1];
        if (kill) stg_d[g].vld = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_q[g] <= '0;
      end else begin
        stg_q[g] <= stg_d[g];
      end
    end
  end

  assign slot_out = stg_q[DEPTH-1];

endmodule

// File: rtl/cbu_redirect_calc.sv
module cbu_redirect_calc
  import cbu_pkg::*;
#(
  parameter int unsigned OFF_W    = 24,
  parameter int unsigned PC_AHEAD = 8,
  parameter int unsigned STEP     = 4
) (
  input  logic [XLEN-1:0]  addr,
  input  logic [OFF_W-1:0] offset,
  output logic [XLEN-1:0]  target,
  output logic [XLEN-1:0]  ret_addr
);

  localparam int unsigned EXT_W = XLEN - OFF_W - 2;

  logic [XLEN-1:0] disp;
  logic [XLEN-1:0] pc_seen;

  assign disp     = {{EXT_W{offset[OFF_W-1]}}, offset, 2'b00};
  assign pc_seen  = addr + XLEN'(PC_AHEAD);
  assign target   = pc_seen + disp;
  assign ret_addr = addr + XLEN'(STEP);

endmodule

// File: rtl/cond_branch_unit.sv
module cond_branch_unit
  import cbu_pkg::*;
#(
  parameter int unsigned OFF_W       = 24,
  parameter int unsigned LINK_REG    = 14,
  parameter int unsigned PIPE_DEPTH  = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fetch_valid,
  input  logic [XLEN-1:0]     fetch_word,
  input  logic [XLEN-1:0]     fetch_pc,
  input  logic [3:0]          flags_nzcv,
  output logic                rf_we,
  output logic [REGIDX_W-1:0] rf_idx,
  output logic [XLEN-1:0]     link_val,
  output logic                br_taken,
  output logic [XLEN-1:0]     br_target,
  output logic                flush
);

  localparam int unsigned IBYTES   = XLEN / 8;
  localparam int unsigned PC_AHEAD = PIPE_DEPTH * IBYTES;
  localparam int unsigned PRED_LSB = XLEN - PRED_W;
  localparam logic [2:0]  BR_CLASS = 3'b101;

  // reset: asserted at once, released on the clock
  logic [SYNC_STAGES-1:0] rsync_q;
  logic [SYNC_STAGES-1:0] rsync_d;
  logic                   core_rst_n;

  assign rsync_d = {rsync_q[SYNC_STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= '0;
    end else begin
      rsync_q <= rsync_d;
    end
  end

  assign core_rst_n = rsync_q[SYNC_STAGES-1];

  // fetch -> decode -> execute slots
  slot_t fetch_slot;
  slot_t ex_slot;

  assign fetch_slot = '{vld: fetch_valid, word: fetch_word, addr: fetch_pc};

  cbu_slot_chain #(.DEPTH(PIPE_DEPTH)) u_slots (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .kill     (flush),
    .slot_in  (fetch_slot),
    .slot_out (ex_slot)
  );

  // predicate
  logic pred_ok;

  cbu_pred_eval u_pred (
    .pred (ex_slot.word[XLEN-1:PRED_LSB]),
    .nzcv (flags_nzcv),
    .pass (pred_ok)
  );

  // redirect and return address
  logic [XLEN-1:0] tgt;
  logic [XLEN-1:0] ret;

  cbu_redirect_calc #(
    .OFF_W    (OFF_W),
    .PC_AHEAD (PC_AHEAD),
    .STEP     (IBYTES)
  ) u_redir (
    .addr     (ex_slot.addr),
    .offset   (ex_slot.word[OFF_W-1:0]),
    .target   (tgt),
    .ret_addr (ret)
  );

  // execute decision
  logic is_branch;
  logic link_bit;
  logic commit;

  assign is_branch = (ex_slot.word[27:25] == BR_CLASS);
  assign link_bit  = ex_slot.word[OFF_W];
  assign commit    = ex_slot.vld && pred_ok;

  always_comb begin
    br_taken = commit && is_branch;
    flush    = br_taken;
    if (is_branch) begin
      rf_we  = commit && link_bit;
      rf_idx = REGIDX_W'(LINK_REG);
    end else begin
      rf_we  = commit;
      rf_idx = ex_slot.word[15:12];
    end
  end

  assign br_target = tgt;
  assign link_val  = ret;

endmodule

// File: rtl/cbu_checker.sv
module cbu_checker
  import cbu_pkg::*;
#(
  parameter int unsigned LINK_REG = 14
) (
  input logic                clk,
  input logic                rst_n,
  input logic                rf_we,
  input logic [REGIDX_W-1:0] rf_idx,
  input logic [XLEN-1:0]     link_val,
  input logic                br_taken,
  input logic [XLEN-1:0]     br_target,
  input logic                flush
);

  // R7
  flush_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!flush && !rf_we && !br_taken));

  // R7
  flush_second_younger_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> ##1 (!rf_we && !br_taken));

  // R5
  link_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && br_taken) |-> (rf_idx == REGIDX_W'(LINK_REG)));

  // R4
  target_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |-> (br_target[1:0] == link_val[1:0]));

endmodule

bind cond_branch_unit cbu_checker #(.LINK_REG(LINK_REG)) u_cbu_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rf_we     (rf_we),
  .rf_idx    (rf_idx),
  .link_val  (link_val),
  .br_taken  (br_taken),
  .br_target (br_target),
  .flush     (flush)
);

// File: tb/tb_cond_branch_unit.sv
`timescale 1ns/1ps
module tb_cond_branch_unit;

  logic        clk;
  logic        rst_n;
  logic        fetch_valid;
  logic [31:0] fetch_word;
  logic [31:0] fetch_pc;
  logic [3:0]  flags_nzcv;
  logic        rf_we;
  logic [3:0]  rf_idx;
  logic [31:0] link_val;
  logic        br_taken;
  logic [31:0] br_target;
  logic        flush;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  cond_branch_unit dut (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_word(fetch_word),
    .fetch_pc(fetch_pc), .flags_nzcv(flags_nzcv), .rf_we(rf_we), .rf_idx(rf_idx),
    .link_val(link_val), .br_taken(br_taken), .br_target(br_target), .flush(flush)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct {
    bit        v;
    bit [31:0] w;
    bit [31:0] a;
  } ent_t;

  ent_t pipe[$];
  logic [31:0] pc;

  function automatic bit ref_pred(input bit [3:0] c, input bit [3:0] f);
    bit n = f[3], z = f[2], cy = f[1], ov = f[0];
    case (c)
      0: return z;        1: return !z;
      2: return cy;       3: return !cy;
      4: return n;        5: return !n;
      6: return ov;       7: return !ov;
      8: return cy && !z; 9: return !cy || z;
      10: return n == ov; 11: return n != ov;
      12: return !z && (n == ov);
      13: return z || (n != ov);
      14: return 1;
      default: return 0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit v, input bit [31:0] w, input bit [3:0] f);
    ent_t e, nw;
    bit pass, isb, e_take, e_we;
    bit [3:0] e_idx;
    bit [31:0] e_tgt;
    @(negedge clk);
    fetch_valid = v; fetch_word = w; fetch_pc = pc; flags_nzcv = f;
    #1;
    e      = pipe[0];
    pass   = ref_pred(e.w[31:28], f);
    isb    = (e.w[27:25] == 3'b101);
    e_take = e.v && pass && isb;
    e_we   = e.v && pass && (!isb || e.w[24]);
    e_idx  = isb ? 4'd14 : e.w[15:12];
    e_tgt  = e.a + 32'd8 + 32'($signed(e.w[23:0])) * 32'd4;
    check(rf_we == e_we, "R1/R2/R3/R8 rf_we", 32'(rf_we), 32'(e_we));
    check(br_taken == e_take, "R4/R6 br_taken", 32'(br_taken), 32'(e_take));
    check(flush == e_take, "R7 flush", 32'(flush), 32'(e_take));
    if (e_we) check(rf_idx == e_idx, "R2/R5 rf_idx", 32'(rf_idx), 32'(e_idx));
    if (e_take) check(br_target == e_tgt, "R4 br_target", br_target, e_tgt);
    if (e_take && e.w[24]) check(link_val == e.a + 32'd4, "R5 link_val", link_val, e.a + 32'd4);
    nw.v = v; nw.w = w; nw.a = pc;
    void'(pipe.pop_front());
    pipe.push_back(nw);
    if (e_take) foreach (pipe[i]) pipe[i].v = 0;
    pc = pc + 32'd4;
  endtask

  function automatic bit [31:0] dop(input bit [3:0] c, input bit [3:0] rd);
    return {c, 3'b000, 9'h0A5, rd, 12'h3C1};
  endfunction

  function automatic bit [31:0] bop(input bit [3:0] c, input bit lk, input bit [23:0] off);
    return {c, 3'b101, lk, off};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; fetch_valid = 0; fetch_word = '0; fetch_pc = '0; flags_nzcv = '0;
    pc = 32'h0000_1000;
    pipe.push_back('{v:0, w:0, a:0});
    pipe.push_back('{v:0, w:0, a:0});
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: outputs quiet in reset
    check(!rf_we && !br_taken && !flush, "R9 reset outputs", {29'd0, rf_we, br_taken, flush}, 32'd0);
    rst_n = 1;
    for (int i = 0; i < 4; i++) step(0, dop(4'hE, 4'd1), 4'h0);

    // R1 R3 R8: every predicate under every flag pattern, back to back
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 16; f++)
        step(1, dop(4'(c), 4'(c)), 4'(f));

    // R8: failed word then passing word, no bubble
    step(1, dop(4'h0, 4'd3), 4'h0);
    step(1, dop(4'h1, 4'd4), 4'h0);
    step(1, dop(4'hE, 4'd5), 4'h0);

    // R5 R7: linked taken branch, two younger words must vanish
    step(1, bop(4'hE, 1, 24'h000010), 4'h0);
    step(1, dop(4'hE, 4'd6), 4'h0);
    step(1, dop(4'hE, 4'd7), 4'h0);
    step(1, dop(4'hE, 4'd8), 4'h0);
    step(1, dop(4'hE, 4'd9), 4'h0);

    // R6: failed branches
    step(1, bop(4'h1, 1, 24'h000020), 4'h4);
    step(1, bop(4'hF, 1, 24'h000020), 4'hF);
    step(1, dop(4'hE, 4'd2), 4'h4);
    step(1, dop(4'hE, 4'd2), 4'h4);

    // R4: extreme offsets and wrap
    pc = 32'hFFFF_FFF0;
    step(1, bop(4'hE, 0, 24'h7FFFFF), 4'h0);
    step(1, dop(4'hE, 4'd1), 4'h0);
    step(1, dop(4'hE, 4'd1), 4'h0);
    pc = 32'h0000_0010;
    step(1, bop(4'hE, 0, 24'h800000), 4'h0);
    step(1, dop(4'hE, 4'd1), 4'h0);
    step(1, dop(4'hE, 4'd1), 4'h0);
    step(1, bop(4'hE, 1, 24'hFFFFFF), 4'h0);
    step(1, bop(4'hE, 1, 24'h000001), 4'h0);
    step(1, bop(4'hE, 1, 24'h000002), 4'h0);
    step(1, dop(4'hE, 4'd1), 4'h0);
    step(1, dop(4'hE, 4'd1), 4'h0);

    // R2 R4 R5 R6 R7 R8: random mix
    for (int i = 0; i < 400; i++) begin
      bit [31:0] w = $urandom;
      if (w[0]) w[27:25] = 3'b101;
      step(($urandom % 5) != 0, w, 4'($urandom));
    end
    for (int i = 0; i < 3; i++) step(0, 32'h0, 4'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule